// File: doc/BRIEF.md
# PCI Bus Hang Watchdog

This block watches a single CPU-initiated transaction on the PCI bus at a time. A pulse on `cycleStart` marks the address phase of a new transaction and records whether it is a configuration access and whether it is a read. For every non-configuration transaction, a timer counts the bus clocks in which the CPU owns the bus. If that count reaches `HANG_LIMIT` before the target completes the transaction, the block ends the transaction with a one-cycle transfer-error acknowledge and sets a sticky hang flag. The default of 2000 clocks at 33 MHz is about 60 microseconds.

Configuration accesses are exempt from the hang timer. Instead, the block watches the device-select input during a short decode window after the address phase. If no target claims the access by the end of that window, the block master-aborts it quietly. It gives a normal acknowledge, supplies all-ones read data or signals that write data is dropped, and records no error. A control input turns the hang timer off. Software clears the hang flag by pulsing the clear input, which models a write of one.

Top module: `pci_hang_watchdog`

## Requirements
- R1: After reset, `errAck`, `okAck`, `wrDrop` and `hangFlag` are 0 and `rdData` is all zeros.
- R2: A non-configuration transaction that is not completed drives `errAck` high for exactly one cycle. This happens right after the HANG_LIMIT-th counted clock edge following the `cycleStart` edge. The transaction then ends.
- R3: The hang timer advances only on clock edges where `busOwned` is 1. Edges without ownership are not counted.
- R4: While `timeoutEn` is 0, no transfer-error acknowledge is produced and the accumulated count is cleared.
- R5: A configuration transaction never produces `errAck`, however long it lasts.
- R6: A configuration transaction drives `okAck` high for one cycle right after the DSEL_WIN-th edge following the `cycleStart` edge, if `devsel` was 0 on every one of those edges. If `devsel` is 1 on any of those edges, no abort occurs.
- R7: During an abort of a configuration read, `rdData` is all ones and `wrDrop` is 0. During an abort of a configuration write, `wrDrop` is 1 and `rdData` is zero. Outside an abort, `rdData` is zero and `wrDrop` is 0.
- R8: A timeout sets `hangFlag`, which stays set. An unclaimed configuration abort leaves `hangFlag` unchanged.
- R9: A `swClear` pulse clears `hangFlag` on the next edge. If a timeout occurs on the same edge, the flag is set.
- R10: `cycleDone` on the edge where a timeout or abort would fire ends the transaction without either response. A new `cycleStart` restarts the count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cycleStart | input | 1 | Address phase of a new CPU transaction |
| isCfgIn | input | 1 | New transaction is a configuration access |
| isReadIn | input | 1 | New transaction is a read |
| busOwned | input | 1 | CPU currently owns the PCI bus |
| devsel | input | 1 | A target claims the transaction |
| cycleDone | input | 1 | Target completed the transaction normally |
| timeoutEn | input | 1 | Hang timer enable |
| swClear | input | 1 | Write-one-to-clear pulse for the hang flag |
| errAck | output | 1 | Transfer-error acknowledge pulse |
| okAck | output | 1 | Normal acknowledge pulse for an unclaimed configuration access |
| wrDrop | output | 1 | Write data of the aborted configuration access is discarded |
| rdData | output | DATA_W | Read data returned on an aborted configuration read |
| hangFlag | output | 1 | Sticky hang status |

## Verification
Directed sequences cover several cases. One is a memory transaction with ownership held throughout, which fixes the exact timeout edge. Another toggles ownership, which separates counting owned clocks from counting all clocks. A third disables the timer, showing that its count is cleared rather than frozen. Configuration reads and writes are run both unclaimed and claimed late in the window, which separates the abort path from the normal wait. The data and drop outputs show which of read or write was recorded. Collisions of completion, clear and restart on the firing edge pin down priorities. Randomised traffic then runs against a cycle model in the bench.

// File: rtl/hang_wd_pkg.sv
package hang_wd_pkg;
  typedef struct packed {
    logic load;       // start of a transaction: clear count and claim, latch type
    logic incCnt;     // advance the counter
    logic clrCnt;     // clear the counter (timer disabled)
    logic setClaim;   // a target claimed the configuration access
    logic fireErr;    // end with transfer-error acknowledge
    logic fireAbort;  // end with quiet master abort
  } strobes_t;

  typedef enum logic {ST_IDLE, ST_BUSY} wdState_t;
endpackage

// File: rtl/hang_wd_ctrl.sv
module hang_wd_ctrl
  import hang_wd_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cycleStart,
  input  logic     busOwned,
  input  logic     devsel,
  input  logic     cycleDone,
  input  logic     timeoutEn,
  input  logic     cfgCur,
  input  logic     claimed,
  input  logic     hangEnd,
  input  logic     winEnd,
  output strobes_t stb
);
  wdState_t state, stateNext;

  always_comb begin
    stb       = '0;
    stateNext = state;
    if (cycleStart) begin
      stb.load  = 1'b1;
      stateNext = ST_BUSY;
    end else if (state == ST_BUSY) begin
      if (cycleDone) begin
        stateNext = ST_IDLE;
      end else if (cfgCur) begin
        if (devsel) stb.setClaim = 1'b1;
        if (!claimed && !devsel && winEnd) begin
          stb.fireAbort = 1'b1;
          stateNext     = ST_IDLE;
        end else if (!claimed) begin
          stb.incCnt = 1'b1;
        end
      end else if (!timeoutEn) begin
        stb.clrCnt = 1'b1;
      end else if (busOwned) begin
        if (hangEnd) begin
          stb.fireErr = 1'b1;
          stateNext   = ST_IDLE;
        end else begin
          stb.incCnt = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // R6: an abort only ever ends a configuration access
  p_abort_cfg_only_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.fireAbort |-> cfgCur);

  // R4: with the timer disabled no error is fired
  p_no_err_disabled_r4: assert property (@(posedge clk) disable iff (!rstN)
    !timeoutEn |-> !stb.fireErr);

  // R3: without ownership no error is fired
  p_no_err_unowned_r3: assert property (@(posedge clk) disable iff (!rstN)
    !busOwned |-> !stb.fireErr);
endmodule

// File: rtl/hang_wd_dpath.sv
module hang_wd_dpath
  import hang_wd_pkg::*;
#(
  parameter int HANG_LIMIT = 2000,
  parameter int DSEL_WIN   = 5,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic              isCfgIn,
  input  logic              isReadIn,
  input  logic              swClear,
  output logic              cfgCur,
  output logic              claimed,
  output logic              hangEnd,
  output logic              winEnd,
  output logic              errAck,
  output logic              okAck,
  output logic              wrDrop,
  output logic [DATA_W-1:0] rdData,
  output logic              hangFlag
);
  localparam int CNT_W = $clog2(HANG_LIMIT + 1);
  localparam logic [CNT_W-1:0] HANG_LAST = CNT_W'(HANG_LIMIT - 1);
  localparam logic [CNT_W-1:0] WIN_LAST  = CNT_W'(DSEL_WIN - 1);

  logic [CNT_W-1:0] cnt;
  logic             readCur;
  logic             abortRd;

  assign hangEnd = (cnt == HANG_LAST);
  assign winEnd  = (cnt == WIN_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      claimed <= 1'b0;
      cfgCur  <= 1'b0;
      readCur <= 1'b0;
    end else if (stb.load) begin
      cnt     <= '0;
      claimed <= 1'b0;
      cfgCur  <= isCfgIn;
      readCur <= isReadIn;
    end else begin
      if (stb.clrCnt)      cnt <= '0;
      else if (stb.incCnt) cnt <= cnt + 1'b1;
      if (stb.setClaim) claimed <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errAck   <= 1'b0;
      okAck    <= 1'b0;
      abortRd  <= 1'b0;
      hangFlag <= 1'b0;
    end else begin
      errAck  <= stb.fireErr;
      okAck   <= stb.fireAbort;
      abortRd <= stb.fireAbort & readCur;
      if (stb.fireErr)   hangFlag <= 1'b1;
      else if (swClear)  hangFlag <= 1'b0;
    end
  end

  assign rdData = (okAck && abortRd) ? '1 : '0;
  assign wrDrop = okAck && !abortRd;

  // R2: at most one termination response at a time
  p_one_resp_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({errAck, okAck}));

  // R2: the error acknowledge is a single-cycle pulse
  p_err_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    errAck |=> !errAck);

  // R5: a timeout never ends a configuration access
  p_cfg_no_err_r5: assert property (@(posedge clk) disable iff (!rstN)
    errAck |-> !cfgCur);

  // R8: a timeout leaves the sticky flag set
  p_flag_on_err_r8: assert property (@(posedge clk) disable iff (!rstN)
    errAck |-> hangFlag);

  // R8: a quiet abort does not raise the flag
  p_abort_no_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    okAck |-> (hangFlag == $past(hangFlag)) || $past(swClear));

  // R9: a clear without a coinciding timeout empties the flag
  p_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(swClear) && !errAck |-> !hangFlag);
endmodule

// File: rtl/pci_hang_watchdog.sv
module pci_hang_watchdog
  import hang_wd_pkg::*;
#(
  parameter int HANG_LIMIT = 2000,
  parameter int DSEL_WIN   = 5,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycleStart,
  input  logic              isCfgIn,
  input  logic              isReadIn,
  input  logic              busOwned,
  input  logic              devsel,
  input  logic              cycleDone,
  input  logic              timeoutEn,
  input  logic              swClear,
  output logic              errAck,
  output logic              okAck,
  output logic              wrDrop,
  output logic [DATA_W-1:0] rdData,
  output logic              hangFlag
);
  strobes_t stb;
  logic cfgCur, claimed, hangEnd, winEnd;

  hang_wd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cycleStart(cycleStart), .busOwned(busOwned),
    .devsel(devsel), .cycleDone(cycleDone), .timeoutEn(timeoutEn),
    .cfgCur(cfgCur), .claimed(claimed), .hangEnd(hangEnd), .winEnd(winEnd),
    .stb(stb)
  );

  hang_wd_dpath #(.HANG_LIMIT(HANG_LIMIT), .DSEL_WIN(DSEL_WIN), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .isCfgIn(isCfgIn), .isReadIn(isReadIn),
    .swClear(swClear), .cfgCur(cfgCur), .claimed(claimed), .hangEnd(hangEnd),
    .winEnd(winEnd), .errAck(errAck), .okAck(okAck), .wrDrop(wrDrop),
    .rdData(rdData), .hangFlag(hangFlag)
  );
endmodule

// File: tb/tb_pci_hang_watchdog.sv
`timescale 1ns/1ps
module tb_pci_hang_watchdog;
  localparam int HL = 48;
  localparam int DW = 5;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cycleStart = 0, isCfgIn = 0, isReadIn = 0, busOwned = 0, devsel = 0;
  logic cycleDone = 0, timeoutEn = 0, swClear = 0;
  logic errAck, okAck, wrDrop, hangFlag;
  logic [DATA_W-1:0] rdData;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pci_hang_watchdog #(.HANG_LIMIT(HL), .DSEL_WIN(DW), .DATA_W(DATA_W)) dut (
    .clk(clk), .rstN(rstN), .cycleStart(cycleStart), .isCfgIn(isCfgIn),
    .isReadIn(isReadIn), .busOwned(busOwned), .devsel(devsel),
    .cycleDone(cycleDone), .timeoutEn(timeoutEn), .swClear(swClear),
    .errAck(errAck), .okAck(okAck), .wrDrop(wrDrop), .rdData(rdData),
    .hangFlag(hangFlag)
  );

  // Reference model built from the requirements
  bit mActive, mCfg, mRd, mClaim, mErr, mAbort, mAbortRd, mFlag;
  int mCnt;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mActive <= 0; mCfg <= 0; mRd <= 0; mClaim <= 0; mCnt <= 0;
      mErr <= 0; mAbort <= 0; mAbortRd <= 0; mFlag <= 0;
    end else begin
      mErr <= 0; mAbort <= 0; mAbortRd <= 0;
      if (swClear) mFlag <= 0;                       // R9
      if (cycleStart) begin                          // R10 restart
        mActive <= 1; mCnt <= 0; mClaim <= 0; mCfg <= isCfgIn; mRd <= isReadIn;
      end else if (mActive) begin
        if (cycleDone) mActive <= 0;                 // R10 completion wins
        else if (mCfg) begin                         // R5, R6
          if (devsel) mClaim <= 1;
          if (!mClaim && !devsel && mCnt == DW - 1) begin
            mAbort <= 1; mAbortRd <= mRd; mActive <= 0;
          end else if (!mClaim) mCnt <= mCnt + 1;
        end else if (!timeoutEn) mCnt <= 0;          // R4
        else if (busOwned) begin                     // R3
          if (mCnt == HL - 1) begin
            mErr <= 1; mFlag <= 1; mActive <= 0;     // R2, R8
          end else mCnt <= mCnt + 1;
        end
      end
    end
  end

  function automatic logic [DATA_W-1:0] expData(bit ab, bit rd);
    return (ab && rd) ? {DATA_W{1'b1}} : '0;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cmpAll();
    chk(errAck == mErr, "R2", "errAck", errAck, mErr);
    chk(okAck == mAbort, "R6", "okAck", okAck, mAbort);
    chk(rdData == expData(mAbort, mAbortRd), "R7", "rdData", rdData, expData(mAbort, mAbortRd));
    chk(wrDrop == (mAbort && !mAbortRd), "R7", "wrDrop", wrDrop, mAbort && !mAbortRd);
    chk(hangFlag == mFlag, "R8", "hangFlag", hangFlag, mFlag);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cycles++;
    cmpAll();
  endtask

  task automatic idleIn();
    cycleStart = 0; devsel = 0; cycleDone = 0; swClear = 0;
  endtask

  task automatic startTxn(bit cfg, bit rd);
    cycleStart = 1; isCfgIn = cfg; isReadIn = rd;
    tick();
    cycleStart = 0;
  endtask

  // run until errAck seen, return edge count after start (0 if none in limit)
  task automatic waitErr(int maxEdges, output int seenAt);
    seenAt = 0;
    for (int k = 1; k <= maxEdges; k++) begin
      tick();
      if (errAck && seenAt == 0) seenAt = k;
    end
  endtask

  task automatic waitAbort(int maxEdges, output int seenAt);
    seenAt = 0;
    for (int k = 1; k <= maxEdges; k++) begin
      tick();
      if (okAck && seenAt == 0) seenAt = k;
    end
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      if (cycles > 150000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    int at;
    void'($urandom(32'h5eed_1234));
    timeoutEn = 1; busOwned = 1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(errAck == 0 && okAck == 0 && wrDrop == 0 && hangFlag == 0, "R1", "ctrl outs", {errAck, okAck, wrDrop, hangFlag}, 0);
    chk(rdData == '0, "R1", "rdData", rdData, 0);
    rstN = 1;
    tick();

    // R2: hang with ownership throughout
    startTxn(0, 1);
    waitErr(HL + 10, at);
    chk(at == HL, "R2", "timeout edge", at, HL);
    chk(hangFlag == 1, "R8", "flag after timeout", hangFlag, 1);

    // R9: clear
    swClear = 1; tick(); swClear = 0;
    chk(hangFlag == 0, "R9", "flag cleared", hangFlag, 0);

    // R3: ownership every other edge doubles the time
    startTxn(0, 0);
    at = 0;
    for (int k = 1; k <= 2 * HL + 10; k++) begin
      busOwned = k[0];
      tick();
      if (errAck && at == 0) at = k;
    end
    busOwned = 1;
    chk(at == 2 * HL - 1, "R3", "timeout edge with gaps", at, 2 * HL - 1);

    // R4: disabled timer never fires and clears count
    startTxn(0, 1);
    repeat (HL - 5) tick();
    timeoutEn = 0; tick(); timeoutEn = 1;
    waitErr(HL + 10, at);
    chk(at == HL, "R4", "count cleared by disable", at, HL);
    startTxn(0, 1);
    timeoutEn = 0;
    waitErr(3 * HL, at);
    chk(at == 0, "R4", "no timeout while disabled", at, 0);
    timeoutEn = 1; cycleDone = 1; tick(); cycleDone = 0;

    // R6, R7: unclaimed config read
    swClear = 1; tick(); swClear = 0;
    startTxn(1, 1);
    at = 0;
    for (int k = 1; k <= DW + 3; k++) begin
      @(posedge clk); @(negedge clk); cycles++;
      cmpAll();
      if (okAck && at == 0) begin
        at = k;
        chk(rdData == {DATA_W{1'b1}}, "R7", "ones on cfg read", rdData, {DATA_W{1'b1}});
        chk(wrDrop == 0, "R7", "no drop on read", wrDrop, 0);
      end
    end
    chk(at == DW, "R6", "abort edge", at, DW);
    chk(hangFlag == 0, "R8", "no flag on abort", hangFlag, 0);

    // R7: unclaimed config write
    startTxn(1, 0);
    at = 0;
    for (int k = 1; k <= DW + 3; k++) begin
      tick();
      if (okAck && at == 0) begin
        at = k;
        chk(wrDrop == 1 && rdData == '0, "R7", "drop on cfg write", {wrDrop, rdData}, 33'h1_0000_0000);
      end
    end
    chk(at == DW, "R6", "write abort edge", at, DW);

    // R5, R6: claimed on last window edge, long wait, no error/abort
    startTxn(1, 1);
    repeat (DW - 1) tick();
    devsel = 1; tick(); devsel = 0;
    waitErr(3 * HL, at);
    chk(at == 0, "R5", "cfg never times out", at, 0);
    chk(okAck == 0, "R6", "claimed no abort", okAck, 0);
    cycleDone = 1; tick(); cycleDone = 0;

    // R9: clear and timeout on the same edge
    startTxn(0, 0);
    repeat (HL - 1) tick();
    swClear = 1; tick(); swClear = 0;
    chk(errAck == 1 && hangFlag == 1, "R9", "set wins over clear", {errAck, hangFlag}, 3);

    // R10: done on the firing edge
    startTxn(0, 0);
    repeat (HL - 1) tick();
    cycleDone = 1; tick(); cycleDone = 0;
    chk(errAck == 0, "R10", "done beats timeout", errAck, 0);
    startTxn(1, 1);
    repeat (DW - 1) tick();
    cycleDone = 1; tick(); cycleDone = 0;
    chk(okAck == 0, "R10", "done beats abort", okAck, 0);

    // R10: restart mid-way
    startTxn(0, 1);
    repeat (HL - 10) tick();
    startTxn(0, 1);
    waitErr(HL + 5, at);
    chk(at == HL, "R10", "restart resets count", at, HL);

    // random traffic
    for (int n = 0; n < 6000; n++) begin
      cycleStart = ($urandom % 40) == 0;
      isCfgIn    = $urandom % 2;
      isReadIn   = $urandom % 2;
      busOwned   = ($urandom % 5) != 0;
      devsel     = ($urandom % 8) == 0;
      cycleDone  = ($urandom % 100) == 0;
      timeoutEn  = ($urandom % 20) != 0;
      swClear    = ($urandom % 60) == 0;
      tick();
    end
    idleIn();
    tick();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule